// File: doc/BRIEF.md
# SPI Serial Flash Command Engine

This block is the slave-side instruction engine of a small SPI NOR flash model. A bus master selects it by pulling the active-low select line, then clocks in an 8-bit opcode, optionally a 24-bit address and data, all most significant bit first. The engine samples the serial input on the rising edge of the serial clock and changes the serial output after the falling edge. Clock idle-low (mode 0) and idle-high (mode 3) framing both work. The serial clock and select are sampled by the system clock `clk`, so they must stay stable for several `clk` periods per phase.

A register array of `2**AW` bytes stands in for the cell array. Program operations can only clear bits. Erase operations restore a sector, a block or the whole array to `8'hFF`. A down-counter models the self-timed busy period of every program and erase. Modifying commands take effect only when select rises after exactly the right number of bits. Any other frame length aborts the command.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset the output enable is low, the status byte reads `8'h00` and every array byte reads `8'hFF`.
- R2: Opcode `8'h03` followed by a 24-bit address streams array bytes from that address for as long as select stays low. Only the low `AW` address bits are used. The pointer wraps from the top address to 0. The first data bit appears after the falling clock edge that ends the address. The stream works in both clock idle levels.
- R3: Opcode `8'h90` or `8'hAB` followed by a 24-bit address outputs `8'hBF` when address bit 0 is 0 and `8'h48` when it is 1. It then alternates between the two bytes until select rises.
- R4: Opcode `8'h05` repeats the status byte continuously. Bit 0 is busy, bit 1 is the write-enable latch, bit 6 is the increment-program mode, and all other bits are 0. This command is served while the engine is busy.
- R5: Opcode `8'h06` sets the write-enable latch and `8'h04` clears it. `8'h04` also leaves increment-program mode. Each acts only when select rises after exactly 8 bits; a shorter frame has no effect.
- R6: Opcode `8'h02`, a 24-bit address and one data byte, with the latch set, stores the bitwise AND of the data and the old byte. Busy stays high for `T_PROG` clocks and the latch clears when busy ends. Without the latch set, the command is ignored.
- R7: Opcode `8'hAF`, an address and a byte (40 bits) with the latch set, programs that byte and enters increment-program mode. Each later 16-bit frame of `8'hAF` plus a byte programs the next address. The latch stays set between bytes.
- R8: Increment-program does not wrap. After the byte at the top address completes, the mode ends and the latch clears.
- R9: Opcode `8'h20` erases the `2**SECT_W`-byte sector that holds the address, and `8'h52` erases the `2**BLK_W`-byte block that holds it. Both need the latch and leave other bytes untouched.
- R10: Opcode `8'h60` erases the whole array when the latch is set, and clears the latch when busy ends.
- R11: While busy, every command except the status read is ignored, and a read or ID frame leaves the output disabled.
- R12: The output enable is high only while read, ID or status data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; its rising edge ends a frame |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data input, sampled on rising `sck` |
| so | output | 1 | Serial data output, updated after falling `sck` |
| so_oe | output | 1 | High when `so` should be driven, low for high impedance |

## Verification
The bench reads across the top of the array to prove the read pointer wraps to address 0. An engine that stopped at the top or lost the high bit would return the wrong third byte. It runs increment-program up to the top address and then sends another continuation frame. A design that wraps or keeps the latch set would corrupt address 0 or report status `8'h42` instead of `8'h00`. Truncated write-enable frames, programs without the latch, and read frames sent during a busy period all check that aborted or blocked commands leave the latch, the array and the output enable untouched. Sector and block erases are checked on their boundary bytes, which catches an erase mask of the wrong width.

// File: rtl/spi_flash_engine.sv
module spi_flash_engine #(
  parameter int AW     = 8,
  parameter int SECT_W = 4,
  parameter int BLK_W  = 6,
  parameter int TW     = 12,
  parameter int T_PROG = 1000,
  parameter int T_SE   = 1200,
  parameter int T_BE   = 1400,
  parameter int T_CE   = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic          sck_q, cs_q;
  logic [5:0]    cnt;
  logic [2:0]    obit;
  logic [7:0]    op, dat, osh;
  logic [23:0]   adr;
  logic [AW-1:0] ptr, aai_ptr;
  logic [TW-1:0] tmr;
  logic          wel, aai, aai_end;

  wire sck_rise = sck & ~sck_q & ~cs_n;
  wire sck_fall = ~sck & sck_q & ~cs_n;
  wire busy     = tmr != '0;
  wire done     = tmr == TW'(1);
  wire go       = cs_n & ~cs_q & ~busy;
  wire [AW-1:0] a = adr[AW-1:0];

  wire rd_op = op == 8'h03;
  wire id_op = (op == 8'h90) || (op == 8'hAB);
  wire sr_op = op == 8'h05;
  wire [7:0] status = {1'b0, aai, 4'b0, wel, busy};
  wire [7:0] nxt = sr_op ? status : id_op ? (ptr[0] ? 8'h48 : 8'hBF) : mem[ptr];

  wire do_wren = go && cnt == 6'd8  && op == 8'h06;
  wire do_wrdi = go && cnt == 6'd8  && op == 8'h04;
  wire do_bp   = go && cnt == 6'd40 && op == 8'h02 && wel && !aai;
  wire do_aai0 = go && cnt == 6'd40 && op == 8'hAF && wel && !aai;
  wire do_aain = go && cnt == 6'd16 && op == 8'hAF && aai;
  wire do_se   = go && cnt == 6'd32 && op == 8'h20 && wel && !aai;
  wire do_be   = go && cnt == 6'd32 && op == 8'h52 && wel && !aai;
  wire do_ce   = go && cnt == 6'd8  && op == 8'h60 && wel && !aai;
  wire wr_en   = do_bp | do_aai0 | do_aain;
  wire [AW-1:0] pa = do_aain ? aai_ptr : a;

  assign so_oe = ~cs_n & ((sr_op && cnt >= 6'd8) || (!busy && (rd_op || id_op) && cnt >= 6'd32));
  assign so    = osh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; cnt <= '0; obit <= '0;
      op <= '0; dat <= '0; osh <= '0; adr <= '0; ptr <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        cnt  <= '0;
        obit <= '0;
      end else if (sck_rise) begin
        dat <= {dat[6:0], si};
        if (cnt != 6'd48) cnt <= cnt + 6'd1;
        if (cnt == 6'd7) op <= {dat[6:0], si};
        if (cnt >= 6'd8 && cnt <= 6'd31) adr <= {adr[22:0], si};
        if (cnt == 6'd31) ptr <= {adr[AW-2:0], si};
      end else if (sck_fall && so_oe) begin
        obit <= obit + 3'd1;
        if (obit == 3'd0) begin
          osh <= nxt;
          ptr <= ptr + 1'b1;
        end else begin
          osh <= {osh[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0; wel <= 1'b0; aai <= 1'b0; aai_end <= 1'b0; aai_ptr <= '0;
    end else begin
      if (wr_en)      tmr <= TW'(T_PROG);
      else if (do_se) tmr <= TW'(T_SE);
      else if (do_be) tmr <= TW'(T_BE);
      else if (do_ce) tmr <= TW'(T_CE);
      else if (busy)  tmr <= tmr - 1'b1;

      if (do_aai0 || do_aain) begin
        aai_ptr <= pa + 1'b1;
        aai_end <= &pa;
      end
      if (do_aai0) aai <= 1'b1;

      if (do_wren) wel <= 1'b1;
      if (do_wrdi) begin
        wel <= 1'b0;
        aai <= 1'b0;
      end
      if (done && (!aai || aai_end)) begin
        wel <= 1'b0;
        aai <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && pa == AW'(i)) mem[i] <= mem[i] & dat;
        if (do_ce ||
            (do_se && (a >> SECT_W) == (AW'(i) >> SECT_W)) ||
            (do_be && (a >> BLK_W)  == (AW'(i) >> BLK_W)))
          mem[i] <= 8'hFF;
      end
    end
  end
endmodule

// File: rtl/spi_flash_engine_chk.sv
module spi_flash_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       so_oe,
  input logic       busy,
  input logic       wel,
  input logic       aai,
  input logic [7:0] op
);
  p_busy_needs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  p_latch_cleared_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !aai) |-> !wel);

  p_aai_holds_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aai |-> wel);

  p_aai_entry_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai) |-> $past(wel));

  p_busy_status_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && so_oe) |-> op == 8'h05);
endmodule

bind spi_flash_engine spi_flash_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .so_oe(so_oe), .busy(busy), .wel(wel), .aai(aai), .op(op)
);

// File: tb/tb_spi_flash_engine.sv
module tb_spi_flash_engine;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic so, so_oe;
  logic mode3 = 0;
  logic oe_seen;
  int   n_run = 0, n_fail = 0;
  int   exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  spi_flash_engine dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_b(input int e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic mon(input logic [7:0] rx);
    int e;
    string t;
    if (exp_q.size() == 0) begin
      check(0, "scoreboard empty", rx, 0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rx == e[7:0], t, rx, e);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      sck = 0; repeat (4) @(negedge clk);
      si = tx[b]; rx[b] = so; oe_seen |= so_oe;
      sck = 1; repeat (4) @(negedge clk);
    end
  endtask

  task automatic cs_lo;
    sck = mode3; oe_seen = 0;
    repeat (2) @(negedge clk);
    cs_n = 0; repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi;
    if (!mode3) begin sck = 0; repeat (4) @(negedge clk); end
    cs_n = 1; repeat (6) @(negedge clk);
    sck = mode3;
  endtask

  task automatic snd(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, 8, r);
  endtask

  task automatic sadr(input logic [23:0] ad);
    snd(ad[23:16]); snd(ad[15:8]); snd(ad[7:0]);
  endtask

  task automatic rcv(input int n);
    logic [7:0] r;
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r);
      mon(r);
    end
  endtask

  task automatic cmd1(input logic [7:0] o);
    cs_lo; snd(o); cs_hi;
  endtask

  task automatic rd(input logic [7:0] o, input logic [23:0] ad, input int n);
    cs_lo; snd(o); sadr(ad); rcv(n); cs_hi;
  endtask

  task automatic rdsr(input logic [7:0] e, input string tag);
    expect_b(e, tag);
    cs_lo; snd(8'h05); rcv(1); cs_hi;
  endtask

  task automatic prog(input logic [7:0] o, input logic [23:0] ad, input logic [7:0] d);
    cs_lo; snd(o); sadr(ad); snd(d); cs_hi;
  endtask

  task automatic erase(input logic [7:0] o, input logic [23:0] ad);
    cs_lo; snd(o); sadr(ad); cs_hi;
  endtask

  task automatic idle;
    repeat (2000) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    check(so_oe == 0, "R1 oe after reset", so_oe, 0);
    rdsr(8'h00, "R1 status after reset");
    expect_b(8'hFF, "R1 array erased"); expect_b(8'hFF, "R1 array erased");
    rd(8'h03, 24'h000010, 2);
    check(so_oe == 0, "R12 oe idle", so_oe, 0);

    cs_lo; xfer(8'h06, 7, r); cs_hi;
    rdsr(8'h00, "R5 short frame ignored");
    cmd1(8'h06);
    rdsr(8'h02, "R5 latch set");
    cmd1(8'h04);
    rdsr(8'h00, "R5 latch cleared");

    cmd1(8'h06);
    prog(8'h02, 24'h000005, 8'hA5);
    rdsr(8'h03, "R4 status while busy");
    cs_lo; snd(8'h03); sadr(24'h000005); oe_seen = 0; xfer(8'h00, 8, r); cs_hi;
    check(oe_seen == 0, "R11 read blocked while busy", oe_seen, 0);
    idle;
    rdsr(8'h00, "R6 latch clears at end");

    prog(8'h02, 24'h000005, 8'h00);
    idle;
    expect_b(8'hA5, "R6 program without latch ignored");
    rd(8'h03, 24'h000005, 1);

    cmd1(8'h06); prog(8'h02, 24'h000005, 8'h3C); idle;
    cmd1(8'h06); prog(8'h02, 24'hAB0000, 8'h11); idle;
    expect_b(8'hFF, "R2 wrap"); expect_b(8'hFF, "R2 wrap"); expect_b(8'h11, "R2 wrap to zero");
    rd(8'h03, 24'h0000FE, 3);
    check(so_oe == 0, "R12 oe after read", so_oe, 0);

    mode3 = 1;
    expect_b(8'hFF, "R2 idle-high read"); expect_b(8'h24, "R6 AND result"); expect_b(8'hFF, "R2 idle-high read");
    rd(8'h03, 24'h000004, 3);
    mode3 = 0;

    expect_b(8'hBF, "R3 id"); expect_b(8'h48, "R3 id"); expect_b(8'hBF, "R3 id"); expect_b(8'h48, "R3 id");
    rd(8'h90, 24'h000000, 4);
    expect_b(8'h48, "R3 id odd"); expect_b(8'hBF, "R3 id odd"); expect_b(8'h48, "R3 id odd");
    rd(8'hAB, 24'h000001, 3);

    cmd1(8'h06);
    prog(8'hAF, 24'h000020, 8'h01); idle;
    rdsr(8'h42, "R7 mode and latch held");
    cs_lo; snd(8'hAF); snd(8'h02); cs_hi; idle;
    cs_lo; snd(8'hAF); snd(8'h03); cs_hi; idle;
    cmd1(8'h04);
    rdsr(8'h00, "R5 exit increment mode");
    expect_b(8'h01, "R7 seq"); expect_b(8'h02, "R7 seq"); expect_b(8'h03, "R7 seq"); expect_b(8'hFF, "R7 seq end");
    rd(8'h03, 24'h000020, 4);

    cmd1(8'h06);
    prog(8'hAF, 24'h0000FE, 8'h0F); idle;
    rdsr(8'h42, "R8 mode before top");
    cs_lo; snd(8'hAF); snd(8'h0E); cs_hi; idle;
    rdsr(8'h00, "R8 mode ends at top");
    cs_lo; snd(8'hAF); snd(8'h00); cs_hi; idle;
    expect_b(8'h0F, "R8 top"); expect_b(8'h0E, "R8 top"); expect_b(8'h11, "R8 no wrap write");
    rd(8'h03, 24'h0000FE, 3);

    cmd1(8'h06); erase(8'h20, 24'h000025); idle;
    expect_b(8'hFF, "R9 sector"); expect_b(8'hFF, "R9 sector"); expect_b(8'hFF, "R9 sector"); expect_b(8'hFF, "R9 sector");
    rd(8'h03, 24'h00001F, 4);
    expect_b(8'h24, "R9 outside sector kept");
    rd(8'h03, 24'h000005, 1);

    cmd1(8'h06); erase(8'h52, 24'h00003F); idle;
    expect_b(8'hFF, "R9 block");
    rd(8'h03, 24'h000000, 1);
    expect_b(8'hFF, "R9 block");
    rd(8'h03, 24'h000005, 1);
    expect_b(8'h0F, "R9 outside block kept");
    rd(8'h03, 24'h0000FE, 1);

    cmd1(8'h06); cmd1(8'h60);
    rdsr(8'h03, "R10 chip erase busy");
    idle;
    expect_b(8'hFF, "R10 chip"); expect_b(8'hFF, "R10 chip");
    rd(8'h03, 24'h0000FE, 2);
    rdsr(8'h00, "R10 latch cleared");

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule